// File: doc/BRIEF.md
# Sixteen-Bit Register Port on an I2C Target

This block is an I2C target that lets an external host read and write a small bank of 16-bit registers held elsewhere on the chip. A system clock that runs much faster than the bus samples SCL and SDA. The block detects START, repeated START and STOP conditions on those samples, decodes the device address and acknowledges each accepted byte. It drives SDA only as an open-drain pull-down enable.

A transaction first loads a register pointer, sent as two bytes. Any number of 16-bit words may follow, each sent high byte first. For a read, the host loads the pointer with a write, issues a repeated START, and sends the device address again with the read bit set. The block then streams words out for as long as the host keeps acknowledging. The inside of the chip sees a plain register-file port. The write side is a one-cycle write strobe with address and data. The read side is a one-cycle read strobe, and the register file returns data on the following cycle.

Top module: `i2c_reg16_port`

## Requirements
- R1: After reset the block releases SDA (`sda_oe` low) and raises neither `reg_wr_en` nor `reg_rd_en`.
- R2: A START followed by an address byte whose upper seven bits are 0101_1xx (any of device addresses 0x2C to 0x2F, with bit 0 of the byte being R/W) is acknowledged. The block acknowledges by pulling SDA low for the ninth bit. Every byte the host writes afterwards is acknowledged the same way.
- R3: An address byte with any other upper seven bits is not acknowledged. No further byte is acknowledged, and no register access occurs, until the next START.
- R4: In a write transfer the two bytes after the address byte form the register pointer, most significant byte first. Only pointer bits 9:0 are used, and bits 15:10 have no effect.
- R5: Each data word is received high byte then low byte. Exactly one `reg_wr_en` pulse follows, carrying the word and the current pointer, after the acknowledge bit of the low byte has ended.
- R6: A word whose low byte is not completed before a STOP is discarded, and no write strobe is issued for it.
- R7: After each complete word is written or read, the pointer advances by one and wraps from 0x3FF to 0x000.
- R8: After a repeated START and an address byte with bit 0 (R/W) set, the block returns the register at the pointer. It sends the high byte then the low byte, most significant bit first, fetching each word with a `reg_rd_en` pulse whose data is taken the cycle after.
- R9: During a read, each host acknowledge makes the block send the next byte. After a host not-acknowledge the block keeps SDA released until the next START or STOP.
- R10: `sda_oe` changes only while the synchronized SCL is low.
- R11: A START or repeated START at any point aborts the current transfer and restarts address decoding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock as seen at the pad |
| sda_i | input | 1 | Bus data as seen at the pad |
| sda_oe | output | 1 | High pulls SDA low, low releases it |
| reg_addr | output | ADDR_W (10) | Register pointer used for both strobes |
| reg_wr_en | output | 1 | One-cycle write strobe |
| reg_wdata | output | 16 | Word to be written |
| reg_rd_en | output | 1 | One-cycle read strobe |
| reg_rdata | input | 16 | Register data, valid the cycle after `reg_rd_en` |

## Verification
The bench covers the address-group boundary: all four accepted device addresses, plus 0x2B, which differs from the group only in the lowest compared bit. A decoder that compared too few or too many bits would acknowledge the wrong device or refuse a valid one. It sends pointers with junk in bits 15:10 and bursts across 0x3FF. A design that decoded the upper pointer bits, or failed to wrap, would write or read the wrong register. A word cut off by STOP after its high byte must leave the register unchanged, which a design committing too early would not do. After the host's final not-acknowledge, the bench clocks extra bits and expects SDA to stay high, which catches a design that keeps shifting data out.

// File: rtl/i2c_reg16_pkg.sv
package i2c_reg16_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,     // no transfer addressed to us
    ST_DEV,      // shifting in the device address byte
    ST_DEV_ACK,  // acknowledging the device address
    ST_RX,       // shifting in a pointer or data byte
    ST_RX_ACK,   // acknowledging a received byte
    ST_TX,       // shifting out a data byte
    ST_TX_ACK,   // host acknowledge slot after a sent byte
    ST_WAIT      // released, waiting for START or STOP
  } bus_state_t;

endpackage

// File: rtl/i2c_reg16_sync.sv
module i2c_reg16_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_prev;
  logic              sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_prev <= scl_pipe[STAGES-1];
      sda_prev <= sda_pipe[STAGES-1];
    end
  end

  assign scl_lvl   = scl_pipe[STAGES-1];
  assign sda_lvl   = sda_pipe[STAGES-1];
  assign scl_rise  =  scl_lvl & ~scl_prev;
  assign scl_fall  = ~scl_lvl &  scl_prev;
  // SDA moving while SCL stays high marks a bus condition (R11)
  assign start_det =  scl_lvl & scl_prev &  sda_prev & ~sda_lvl;
  assign stop_det  =  scl_lvl & scl_prev & ~sda_prev &  sda_lvl;

endmodule

// File: rtl/i2c_reg16_ctrl.sv
module i2c_reg16_ctrl
  import i2c_reg16_pkg::*;
#(
  parameter int         ADDR_W        = 10,
  parameter logic [6:0] DEV_ADDR      = 7'h2C,
  parameter int         DEV_DONT_CARE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_lvl,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  output logic              sda_oe,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              reg_wr_en,
  output logic [15:0]       reg_wdata,
  output logic              reg_rd_en,
  input  logic [15:0]       reg_rdata
);

  localparam int CMP_W  = 7 - DEV_DONT_CARE;
  localparam int PTR_HI = ADDR_W - 8;

  bus_state_t        state_q, state_d;
  logic [2:0]        bitcnt_q, bitcnt_d;
  logic              full_q, full_d;
  logic [7:0]        rx_q, rx_d;
  logic [7:0]        tx_q, tx_d;
  logic              rw_q, rw_d;
  logic [1:0]        widx_q, widx_d;
  logic              on_hi_q, on_hi_d;
  logic              hack_q, hack_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic [7:0]        dhi_q, dhi_d;
  logic              pend_q, pend_d;
  logic [15:0]       word_q, word_d;
  logic [15:0]       wdata_q, wdata_d;
  logic              fetch_q, fetch_d;
  logic              cap_q, cap_d;
  logic              wr_q, wr_d;
  logic              oe_q, oe_d;
  logic              dev_hit;

  assign dev_hit = (rx_q[7 -: CMP_W] == DEV_ADDR[6 -: CMP_W]);

  always_comb begin
    state_d  = state_q;
    bitcnt_d = bitcnt_q;
    full_d   = full_q;
    rx_d     = rx_q;
    tx_d     = tx_q;
    rw_d     = rw_q;
    widx_d   = widx_q;
    on_hi_d  = on_hi_q;
    hack_d   = hack_q;
    ptr_d    = ptr_q;
    dhi_d    = dhi_q;
    pend_d   = pend_q;
    wdata_d  = wdata_q;
    oe_d     = oe_q;
    fetch_d  = 1'b0;
    wr_d     = 1'b0;
    cap_d    = fetch_q;
    word_d   = cap_q ? reg_rdata : word_q;
    if (wr_q) ptr_d = ptr_q + ADDR_W'(1);

    if (start_det) begin
      state_d  = ST_DEV;
      bitcnt_d = '0;
      full_d   = 1'b0;
      oe_d     = 1'b0;
      pend_d   = 1'b0;
    end else if (stop_det) begin
      state_d  = ST_IDLE;
      oe_d     = 1'b0;
      pend_d   = 1'b0;
    end else begin
      case (state_q)
        ST_DEV, ST_RX: begin
          if (scl_rise && !full_q) begin
            rx_d     = {rx_q[6:0], sda_lvl};
            bitcnt_d = bitcnt_q + 3'd1;
            if (bitcnt_q == 3'd7) full_d = 1'b1;
          end
          if (scl_fall && full_q) begin
            full_d   = 1'b0;
            bitcnt_d = '0;
            if (state_q == ST_DEV) begin
              if (dev_hit) begin
                state_d = ST_DEV_ACK;
                oe_d    = 1'b1;
                rw_d    = rx_q[0];
                widx_d  = 2'd0;
                fetch_d = rx_q[0];
              end else begin
                state_d = ST_WAIT;
              end
            end else begin
              state_d = ST_RX_ACK;
              oe_d    = 1'b1;
              case (widx_q)
                2'd0:    ptr_d[ADDR_W-1:8] = rx_q[PTR_HI-1:0];
                2'd1:    ptr_d[7:0]        = rx_q;
                2'd2:    dhi_d             = rx_q;
                default: begin
                  wdata_d = {dhi_q, rx_q};
                  pend_d  = 1'b1;
                end
              endcase
            end
          end
        end
        ST_DEV_ACK: begin
          if (scl_fall) begin
            if (rw_q) begin
              state_d = ST_TX;
              tx_d    = word_q[15:8];
              oe_d    = ~word_q[15];
              on_hi_d = 1'b1;
            end else begin
              state_d = ST_RX;
              oe_d    = 1'b0;
            end
          end
        end
        ST_RX_ACK: begin
          if (scl_fall) begin
            state_d = ST_RX;
            oe_d    = 1'b0;
            widx_d  = (widx_q == 2'd3) ? 2'd2 : widx_q + 2'd1;
            if (pend_q) begin
              wr_d   = 1'b1;
              pend_d = 1'b0;
            end
          end
        end
        ST_TX: begin
          if (scl_rise && !full_q) begin
            bitcnt_d = bitcnt_q + 3'd1;
            if (bitcnt_q == 3'd7) full_d = 1'b1;
          end
          if (scl_fall) begin
            if (full_q) begin
              full_d   = 1'b0;
              bitcnt_d = '0;
              state_d  = ST_TX_ACK;
              oe_d     = 1'b0;
              if (!on_hi_q) begin
                ptr_d   = ptr_q + ADDR_W'(1);
                fetch_d = 1'b1;
              end
            end else begin
              tx_d = {tx_q[6:0], 1'b0};
              oe_d = ~tx_q[6];
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) hack_d = ~sda_lvl;
          if (scl_fall) begin
            if (hack_q) begin
              state_d = ST_TX;
              if (on_hi_q) begin
                tx_d    = word_q[7:0];
                oe_d    = ~word_q[7];
                on_hi_d = 1'b0;
              end else begin
                tx_d    = word_q[15:8];
                oe_d    = ~word_q[15];
                on_hi_d = 1'b1;
              end
            end else begin
              state_d = ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      bitcnt_q <= '0;
      full_q   <= 1'b0;
      rx_q     <= '0;
      tx_q     <= '0;
      rw_q     <= 1'b0;
      widx_q   <= '0;
      on_hi_q  <= 1'b0;
      hack_q   <= 1'b0;
      ptr_q    <= '0;
      dhi_q    <= '0;
      pend_q   <= 1'b0;
      word_q   <= '0;
      wdata_q  <= '0;
      fetch_q  <= 1'b0;
      cap_q    <= 1'b0;
      wr_q     <= 1'b0;
      oe_q     <= 1'b0;
    end else begin
      state_q  <= state_d;
      bitcnt_q <= bitcnt_d;
      full_q   <= full_d;
      rx_q     <= rx_d;
      tx_q     <= tx_d;
      rw_q     <= rw_d;
      widx_q   <= widx_d;
      on_hi_q  <= on_hi_d;
      hack_q   <= hack_d;
      ptr_q    <= ptr_d;
      dhi_q    <= dhi_d;
      pend_q   <= pend_d;
      word_q   <= word_d;
      wdata_q  <= wdata_d;
      fetch_q  <= fetch_d;
      cap_q    <= cap_d;
      wr_q     <= wr_d;
      oe_q     <= oe_d;
    end
  end

  assign sda_oe    = oe_q;
  assign reg_addr  = ptr_q;
  assign reg_wr_en = wr_q;
  assign reg_wdata = wdata_q;
  assign reg_rd_en = fetch_q;

  // R10: the pull-down only moves while SCL is low
  a_r10_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe_q) |-> !scl_lvl);

  // R5: a commit follows the cycle that ended the low-byte acknowledge
  a_r5_commit_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q |-> $past(oe_q));

  // R3: writes only happen in a write-direction transfer
  a_r3_no_write_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q |-> !rw_q);

  // R7: pointer steps by one after each committed word
  a_r7_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q |=> ptr_q == ADDR_W'($past(ptr_q) + ADDR_W'(1)));

  // R8: read strobe is a single-cycle pulse
  a_r8_rd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_q |=> !fetch_q);

  // R9: after a refused address or a final not-acknowledge SDA stays released
  a_r9_wait_released: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT) |-> !oe_q);

endmodule

// File: rtl/i2c_reg16_port.sv
module i2c_reg16_port #(
  parameter int         ADDR_W        = 10,
  parameter logic [6:0] DEV_ADDR      = 7'h2C,
  parameter int         DEV_DONT_CARE = 2,
  parameter int         SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              reg_wr_en,
  output logic [15:0]       reg_wdata,
  output logic              reg_rd_en,
  input  logic [15:0]       reg_rdata
);

  logic [1:0] rst_pipe;
  logic       core_rst_n;
  logic       scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign core_rst_n = rst_pipe[1];

  i2c_reg16_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_lvl   (scl_lvl),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_reg16_ctrl #(
    .ADDR_W        (ADDR_W),
    .DEV_ADDR      (DEV_ADDR),
    .DEV_DONT_CARE (DEV_DONT_CARE)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .scl_lvl   (scl_lvl),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_oe    (sda_oe),
    .reg_addr  (reg_addr),
    .reg_wr_en (reg_wr_en),
    .reg_wdata (reg_wdata),
    .reg_rd_en (reg_rd_en),
    .reg_rdata (reg_rdata)
  );

  // R1: no strobe while reset is being released
  a_r1_quiet_in_reset: assert property (@(posedge clk)
    !core_rst_n |-> !reg_wr_en && !reg_rd_en && !sda_oe);

endmodule

// File: tb/i2c_reg16_port_bench.sv
module i2c_reg16_port_bench;

  localparam int Q = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl = 1'b1;
  logic        host_low = 1'b0;
  wire         sda_bus;
  logic        sda_oe;
  logic [9:0]  reg_addr;
  logic        reg_wr_en, reg_rd_en;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic [15:0] mem [1024];
  logic [25:0] exp_q [$];
  int          checks = 0;
  int          errors = 0;
  int          r10_viol = 0;
  logic        done = 1'b0;
  logic        oe_prev = 1'b0;

  always #5 clk = ~clk;

  assign sda_bus = !(host_low || sda_oe);

  i2c_reg16_port u_i2c_reg16_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl),
    .sda_i     (sda_bus),
    .sda_oe    (sda_oe),
    .reg_addr  (reg_addr),
    .reg_wr_en (reg_wr_en),
    .reg_wdata (reg_wdata),
    .reg_rd_en (reg_rd_en),
    .reg_rdata (reg_rdata)
  );

  function automatic logic [15:0] init_val(int i);
    return 16'(i * 37) ^ 16'h5A00;
  endfunction

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = init_val(i);
    reg_rdata = '0;
  end

  // register file model: write strobe, read with one cycle of latency
  always @(posedge clk) begin
    if (reg_wr_en) mem[reg_addr] <= reg_wdata;
    if (reg_rd_en) reg_rdata <= mem[reg_addr];
  end

  task automatic check_eq(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor for writes (R5, R3, R6)
  always @(negedge clk) begin
    if (rst_n && reg_wr_en) begin
      if (exp_q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R3/R6 unexpected write: actual=%h expected=none", {reg_addr, reg_wdata});
      end else begin
        check_eq("R5 write", {6'd0, reg_addr, reg_wdata}, {6'd0, exp_q.pop_front()});
      end
    end
  end

  // R10: pull-down must not move while SCL is high
  always @(negedge clk) begin
    if (rst_n && scl && (sda_oe !== oe_prev)) r10_viol++;
    oe_prev <= sda_oe;
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_bit(input logic b, output logic seen);
    tick(Q); host_low = !b;
    tick(Q); scl = 1'b1;
    tick(Q); seen = sda_bus;
    tick(Q); scl = 1'b0;
  endtask

  task automatic bus_start();
    tick(Q); host_low = 1'b0;
    tick(Q); scl = 1'b1;
    tick(Q); host_low = 1'b1;
    tick(Q); scl = 1'b0;
  endtask

  task automatic bus_stop();
    tick(Q); host_low = 1'b1;
    tick(Q); scl = 1'b1;
    tick(Q); host_low = 1'b0;
    tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
    bus_bit(1'b1, s);
    ack = !s;
  endtask

  task automatic recv_byte(input logic host_ack, output logic [7:0] b);
    logic s;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      bus_bit(1'b1, s);
      b = {b[6:0], s};
    end
    bus_bit(!host_ack, s);
  endtask

  // driver: write transfer, expected commits pushed to the scoreboard
  task automatic write_txn(input logic [6:0] dev, input logic [15:0] ptr, input int n,
                           input logic [15:0] w0, input logic [15:0] w1, input logic exp_ack);
    logic ack;
    logic [15:0] w;
    bus_start();
    send_byte({dev, 1'b0}, ack);
    check_eq(exp_ack ? "R2 address ack" : "R3 address nack", 32'(ack), 32'(exp_ack));
    send_byte(ptr[15:8], ack);
    check_eq("R4 pointer high ack", 32'(ack), 32'(exp_ack));
    send_byte(ptr[7:0], ack);
    check_eq("R4 pointer low ack", 32'(ack), 32'(exp_ack));
    for (int k = 0; k < n; k++) begin
      w = (k == 0) ? w0 : w1;
      if (exp_ack) exp_q.push_back({10'(ptr[9:0] + 10'(k)), w});
      send_byte(w[15:8], ack);
      check_eq("R5 data high ack", 32'(ack), 32'(exp_ack));
      send_byte(w[7:0], ack);
      check_eq("R5 data low ack", 32'(ack), 32'(exp_ack));
    end
    bus_stop();
    tick(4 * Q);
  endtask

  // read with pointer load, repeated START (R11), burst and final NACK
  task automatic read_txn(input logic [6:0] dev, input logic [15:0] ptr, input int n,
                          input logic [15:0] e0, input logic [15:0] e1, input logic [15:0] e2);
    logic ack, s;
    logic [7:0] hi, lo;
    logic [15:0] e;
    int rel;
    bus_start();
    send_byte({dev, 1'b0}, ack);
    check_eq("R2 address ack", 32'(ack), 32'd1);
    send_byte(ptr[15:8], ack);
    send_byte(ptr[7:0], ack);
    check_eq("R4 pointer ack", 32'(ack), 32'd1);
    bus_start();
    send_byte({dev, 1'b1}, ack);
    check_eq("R11 ack after repeated START", 32'(ack), 32'd1);
    for (int k = 0; k < n; k++) begin
      e = (k == 0) ? e0 : ((k == 1) ? e1 : e2);
      recv_byte(1'b1, hi);
      recv_byte(k < n - 1, lo);
      check_eq("R8/R7 read word", 32'({hi, lo}), 32'(e));
    end
    rel = 0;
    for (int i = 0; i < 9; i++) begin
      bus_bit(1'b1, s);
      if (s) rel++;
    end
    check_eq("R9 released after NACK", 32'(rel), 32'd9);
    bus_stop();
    tick(4 * Q);
  endtask

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(5);
    check_eq("R1 sda released", 32'(sda_oe), 32'd0);
    check_eq("R1 no strobes", 32'({reg_wr_en, reg_rd_en}), 32'd0);

    // R2, R4, R5: bits 15:10 of the pointer are junk
    write_txn(7'h2C, 16'hFC12, 2, 16'h1234, 16'hBEEF, 1'b1);
    // R7: burst across the top of the space
    write_txn(7'h2F, 16'h03FF, 2, 16'h0F0F, 16'hF0F0, 1'b1);
    // R6: one whole word, then a high byte cut by STOP
    begin
      logic ack;
      bus_start();
      send_byte({7'h2D, 1'b0}, ack);
      check_eq("R2 address ack", 32'(ack), 32'd1);
      send_byte(8'h01, ack);
      send_byte(8'h00, ack);
      exp_q.push_back({10'h100, 16'h5555});
      send_byte(8'h55, ack);
      send_byte(8'h55, ack);
      send_byte(8'hAA, ack);
      check_eq("R6 partial high ack", 32'(ack), 32'd1);
      bus_stop();
      tick(4 * Q);
    end
    // R3: neighbour address 0x2B and an unrelated one, both refused
    write_txn(7'h2B, 16'h0012, 1, 16'hDEAD, 16'h0000, 1'b0);
    write_txn(7'h24, 16'h0013, 1, 16'hDEAD, 16'h0000, 1'b0);

    read_txn(7'h2E, 16'h8012, 3, 16'h1234, 16'hBEEF, init_val(16'h014));
    read_txn(7'h2F, 16'h03FF, 2, 16'h0F0F, 16'hF0F0, 16'h0000);
    read_txn(7'h2D, 16'h0100, 2, 16'h5555, init_val(16'h101), 16'h0000);

    check_eq("R5 all expected writes seen", 32'(exp_q.size()), 32'd0);
    check_eq("R10 drive changes only with SCL low", 32'(r10_viol), 32'd0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule